// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous, single-bit-wide DRAM alive. It brings the memory up after power-on and then issues periodic refresh cycles. After reset it waits out a fixed pause. It then runs a burst of refresh cycles on its own, while it alone owns the strobes. Only after that burst does it raise `init_done`, and the access controller must hold off all host traffic until that flag is high.

In normal running, an interval timer adds one entry to a backlog of owed refreshes. The backlog saturates, so missed intervals are kept only up to a limit. While the backlog is non-zero the block raises `ref_req` to the access controller. The controller answers with `ref_gnt` once the bus is idle and any open row has been closed. While the grant stays high, the block serves its whole backlog back to back and then drops the request.

By default each refresh is a column-strobe-first cycle: the column strobe falls before the row strobe, write-enable stays high and the address lines sit at zero. A parameter selects a row-strobe-only variant instead. In that variant the column strobe never falls, and an internal row counter supplies the address.

Top module: `dref_seq`

## Requirements
- R1: While `rst` is high: `ras_n`, `cas_n` and `we_n` are 1; `ref_req`, `bus_own` and `init_done` are 0; `backlog` is 0.
- R2: No row-strobe fall occurs within `PAUSE_CYC` cycles of reset release. Exactly `INIT_REFS` refresh cycles take place before `init_done` rises, and `init_done` then stays high until reset.
- R3: In the column-first mode, every fall of `cas_n` happens while `ras_n` is high, after `ras_n` has been high for at least the row-to-column precharge count. `cas_n` has been low for at least the column setup count when `ras_n` falls.
- R4: In the column-first mode, `cas_n` is low in the cycle in which `ras_n` falls. It stays low for at least the column hold count of cycles after that fall.
- R5: `ras_n` stays low for exactly the row-active count of cycles. Between two refresh cycles it stays high for at least the row precharge count.
- R6: `we_n` is never driven low. During column-first refresh, `addr` is all zeros.
- R7: Once `init_done` is high, `backlog` grows by one every `INTERVAL_CYC` cycles. The first increment lands exactly `INTERVAL_CYC` cycles after `init_done` rises.
- R8: `backlog` saturates at `MAX_PEND`, and further intervals are dropped.
- R9: After init, `ref_req` is high whenever `backlog` is non-zero. No refresh cycle starts while `ref_gnt` is low.
- R10: While `ref_gnt` is held, the backlog is served back to back until it is empty and then `ref_req` falls. Every interval that was not dropped yields exactly one refresh cycle.
- R11: `ras_n` and `cas_n` are both high whenever `bus_own` is low.
- R12: With `RAS_ONLY=1`, `cas_n` never falls. The value on `addr` at the k-th row-strobe fall after reset is k modulo `ROWS`, with k counted from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period `CLK_NS` ns |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Access controller has released the bus and closed its row |
| ref_req | output | 1 | Refresh owed or in progress (after init) |
| bus_own | output | 1 | Sequencer is driving the DRAM strobes this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Multiplexed address; zero or refresh row |
| init_done | output | 1 | Power-up pause and initial refresh burst completed |
| backlog | output | $clog2(MAX_PEND+1) | Number of owed refresh cycles |

## Verification
The assertions rely on the access controller keeping `ref_gnt` high from the moment it grants until `ref_req` falls. They also take the timing counts as at least one cycle each, with the column hold shorter than the row-active time. The stimulus respects both. It raises the grant only at random points and lowers it only after the request has dropped. It keeps every random no-grant gap below the span that would fill the backlog. Only one directed phase withholds the grant long enough to reach saturation.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [2:0] {
        CY_IDLE,
        CY_SETUP,
        CY_CAS,
        CY_RAS,
        CY_PRE
    } cyc_st_e;

    typedef enum logic [1:0] {
        SQ_PAUSE,
        SQ_INIT,
        SQ_RUN
    } seq_st_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    // Round a nanosecond figure up to whole clock cycles, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    localparam int DEF_PAUSE_CYC    = 20000; // 200 us at 10 ns
    localparam int DEF_INTERVAL_CYC = 1560;  // 16 ms / 1024 rows at 10 ns
    localparam int DEF_INIT_REFS    = 8;
    localparam int DEF_MAX_PEND     = 8;

endpackage

// File: rtl/dref_backlog.sv
module dref_backlog #(
    parameter int INTERVAL_CYC = 1560,
    parameter int MAX_PEND     = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic                          take,
    output logic [$clog2(MAX_PEND+1)-1:0] count
);
    localparam int IW = $clog2(INTERVAL_CYC + 1);
    localparam int PW = $clog2(MAX_PEND + 1);

    logic [IW-1:0] ival_q;
    logic          tick;
    logic          inc;
    logic          dec;

    assign tick = en && (ival_q == IW'(INTERVAL_CYC - 1));
    assign inc  = tick && (count != PW'(MAX_PEND));
    assign dec  = take && (count != '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ival_q <= '0;
        end else if (tick) begin
            ival_q <= '0;
        end else begin
            ival_q <= ival_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + 1'b1;
        end else if (dec && !inc) begin
            count <= count - 1'b1;
        end
    end

    AST_BACKLOG_MAX: assert property (@(posedge clk) disable iff (rst)
        count <= PW'(MAX_PEND)); // R8
    AST_BACKLOG_STEP: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + 1'b1)
        || (count == $past(count) - 1'b1)); // R7

endmodule

// File: rtl/dref_cbr_cycle.sv
module dref_cbr_cycle
    import dref_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int T_RPC_NS = 5,
    parameter int T_CSR_NS = 10,
    parameter int T_CHR_NS = 10,
    parameter int T_RAS_NS = 60,
    parameter int T_RP_NS  = 40,
    parameter int RAS_ONLY = 0,
    parameter int ADDR_W   = 11,
    parameter int ROWS     = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output strobe_t           strb,
    output logic [ADDR_W-1:0] addr
);
    localparam int RPC_C = ns2cyc(T_RPC_NS, CLK_NS);
    localparam int CSR_C = ns2cyc(T_CSR_NS, CLK_NS);
    localparam int CHR_C = ns2cyc(T_CHR_NS, CLK_NS);
    localparam int RAS_C = ns2cyc(T_RAS_NS, CLK_NS);
    localparam int RP_C  = ns2cyc(T_RP_NS, CLK_NS);
    localparam int CW    = $clog2(RPC_C + CSR_C + RAS_C + RP_C + 1);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    cyc_st_e       st;
    logic [CW-1:0] cnt;
    logic          last;
    logic          done;

    always_comb begin
        case (st)
            CY_SETUP: last = (cnt == CW'(RPC_C - 1));
            CY_CAS:   last = (cnt == CW'(CSR_C - 1));
            CY_RAS:   last = (cnt == CW'(RAS_C - 1));
            CY_PRE:   last = (cnt == CW'(RP_C - 1));
            default:  last = 1'b0;
        endcase
    end

    assign busy = (st != CY_IDLE);
    assign done = (st == CY_PRE) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CY_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                CY_IDLE: begin
                    cnt <= '0;
                    if (start) st <= CY_SETUP;
                end
                CY_SETUP: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) st <= (RAS_ONLY != 0) ? CY_RAS : CY_CAS;
                end
                CY_CAS: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) st <= CY_RAS;
                end
                CY_RAS: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) st <= CY_PRE;
                end
                CY_PRE: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) st <= CY_IDLE;
                end
                default: st <= CY_IDLE;
            endcase
        end
    end

    always_comb begin
        strb.ras_n = (st != CY_RAS);
        strb.we_n  = 1'b1;
        if (RAS_ONLY != 0) begin
            strb.cas_n = 1'b1;
        end else begin
            strb.cas_n = !((st == CY_CAS) || ((st == CY_RAS) && (cnt < CW'(CHR_C))));
        end
    end

    generate
        if (RAS_ONLY != 0) begin : g_row
            logic [ROW_W-1:0] row_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    row_q <= '0;
                end else if (done) begin
                    row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
                end
            end
            assign addr = busy ? ADDR_W'(row_q) : '0;
        end else begin : g_zero
            assign addr = '0;
        end
    endgenerate

    AST_CAS_FIRST: assert property (@(posedge clk) disable iff (rst)
        ((RAS_ONLY == 0) && $fell(strb.ras_n)) |-> $past(!strb.cas_n)); // R3
    AST_CAS_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((RAS_ONLY == 0) && $fell(strb.ras_n)) |-> !strb.cas_n); // R4

endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dref_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int PAUSE_CYC    = DEF_PAUSE_CYC,
    parameter int INTERVAL_CYC = DEF_INTERVAL_CYC,
    parameter int INIT_REFS    = DEF_INIT_REFS,
    parameter int MAX_PEND     = DEF_MAX_PEND,
    parameter int T_RPC_NS     = 5,
    parameter int T_CSR_NS     = 10,
    parameter int T_CHR_NS     = 10,
    parameter int T_RAS_NS     = 60,
    parameter int T_RP_NS      = 40,
    parameter int RAS_ONLY     = 0,
    parameter int ADDR_W       = 11,
    parameter int ROWS         = 1024
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ref_gnt,
    output logic                          ref_req,
    output logic                          bus_own,
    output logic                          ras_n,
    output logic                          cas_n,
    output logic                          we_n,
    output logic [ADDR_W-1:0]             addr,
    output logic                          init_done,
    output logic [$clog2(MAX_PEND+1)-1:0] backlog
);
    localparam int PCW = $clog2(PAUSE_CYC + 1);
    localparam int ICW = $clog2(INIT_REFS + 1);

    seq_st_e        st;
    logic [PCW-1:0] pause_q;
    logic [ICW-1:0] init_left;
    logic           cyc_busy;
    logic           start;
    strobe_t        strb;

    assign init_done = (st == SQ_RUN);

    always_comb begin
        start = 1'b0;
        if (!cyc_busy) begin
            if (st == SQ_INIT) start = (init_left != '0);
            else if (st == SQ_RUN) start = (backlog != '0) && ref_gnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_PAUSE;
            pause_q   <= '0;
            init_left <= ICW'(INIT_REFS);
        end else begin
            case (st)
                SQ_PAUSE: begin
                    pause_q <= pause_q + 1'b1;
                    if (pause_q == PCW'(PAUSE_CYC - 1)) st <= SQ_INIT;
                end
                SQ_INIT: begin
                    if (start) init_left <= init_left - 1'b1;
                    if ((init_left == '0) && !cyc_busy) st <= SQ_RUN;
                end
                default: st <= SQ_RUN;
            endcase
        end
    end

    dref_backlog #(
        .INTERVAL_CYC(INTERVAL_CYC),
        .MAX_PEND    (MAX_PEND)
    ) u_backlog (
        .clk  (clk),
        .rst  (rst),
        .en   (init_done),
        .take (start && init_done),
        .count(backlog)
    );

    dref_cbr_cycle #(
        .CLK_NS  (CLK_NS),
        .T_RPC_NS(T_RPC_NS),
        .T_CSR_NS(T_CSR_NS),
        .T_CHR_NS(T_CHR_NS),
        .T_RAS_NS(T_RAS_NS),
        .T_RP_NS (T_RP_NS),
        .RAS_ONLY(RAS_ONLY),
        .ADDR_W  (ADDR_W),
        .ROWS    (ROWS)
    ) u_cycle (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .busy (cyc_busy),
        .strb (strb),
        .addr (addr)
    );

    assign ras_n   = strb.ras_n;
    assign cas_n   = strb.cas_n;
    assign we_n    = strb.we_n;
    assign bus_own = cyc_busy;
    assign ref_req = init_done && ((backlog != '0) || cyc_busy);

    AST_GRANT_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
        (init_done && start) |-> ref_gnt); // R9
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !bus_own); // R5
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(init_done) |-> init_done); // R2
    AST_QUIET_UNOWNED: assert property (@(posedge clk) disable iff (rst)
        !bus_own |-> (ras_n && cas_n)); // R11

endmodule

// File: tb/sim_dref_seq.sv
`timescale 1ns/1ps
module sim_dref_seq;
    localparam int B_PAUSE = 300;
    localparam int B_INT   = 400;
    localparam int B_REFS  = 8;
    localparam int B_MAXP  = 8;
    localparam int B_ROWS  = 1024;
    // expected cycle counts at 10 ns: 5ns,10ns,10ns,60ns,40ns rounded up
    localparam int E_RPC = 1;
    localparam int E_CSR = 1;
    localparam int E_CHR = 1;
    localparam int E_RAS = 6;
    localparam int E_RP  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b0;
    logic req, own, ras_n, cas_n, we_n, init_done;
    logic [10:0] addr;
    logic [3:0]  backlog;
    logic u1_req, u1_own, u1_ras_n, u1_cas_n, u1_we_n, u1_init;
    logic [10:0] u1_addr;
    logic [3:0]  u1_backlog;

    always #5 clk = ~clk;

    dref_seq #(.PAUSE_CYC(B_PAUSE), .INTERVAL_CYC(B_INT), .INIT_REFS(B_REFS),
               .MAX_PEND(B_MAXP)) u0 (
        .clk(clk), .rst(rst), .ref_gnt(gnt), .ref_req(req), .bus_own(own),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .init_done(init_done), .backlog(backlog));

    dref_seq #(.PAUSE_CYC(B_PAUSE), .INTERVAL_CYC(B_INT), .INIT_REFS(B_REFS),
               .MAX_PEND(B_MAXP), .RAS_ONLY(1), .ROWS(B_ROWS)) u1 (
        .clk(clk), .rst(rst), .ref_gnt(1'b1), .ref_req(u1_req), .bus_own(u1_own),
        .ras_n(u1_ras_n), .cas_n(u1_cas_n), .we_n(u1_we_n), .addr(u1_addr),
        .init_done(u1_init), .backlog(u1_backlog));

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected refresh model
    int  since_init = 0;
    bit  seen_init = 1'b0;
    int  ticks_total = 0;
    int  served_total = 0;
    int  init_falls = 0;
    int  cyc_after_rst = 0;
    int  first_fall = -1;
    int  u1_k = 0;

    // monitor state
    logic p_ras = 1'b1, p_cas = 1'b1, p_u1ras = 1'b1;
    int   ras_hi = 1000, ras_lo = 0, cas_lo = 0, since_fall = 0, n_falls = 0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc_after_rst++;
            if (init_done) begin
                if (seen_init) since_init++;
                seen_init = 1'b1;
                if (since_init > 0 && (since_init % B_INT) == 0) ticks_total++;
            end
            chk(we_n == 1'b1, "R6 we_n high", we_n, 1);
            if (!own) chk(ras_n && cas_n, "R11 strobes idle when not owned", {ras_n, cas_n}, 3);
            // column strobe fall
            if (p_cas && !cas_n)
                chk(ras_n && ras_hi >= E_RPC, "R3 ras high before cas fall", ras_hi, E_RPC);
            // row strobe fall
            if (p_ras && !ras_n) begin
                chk(!cas_n && cas_lo >= E_CSR, "R3 cas setup before ras fall", cas_lo, E_CSR);
                chk(addr == '0, "R6 addr zero in refresh", int'(addr), 0);
                if (n_falls > 0) chk(ras_hi >= E_RP, "R5 ras precharge", ras_hi, E_RP);
                if (first_fall < 0) begin
                    first_fall = cyc_after_rst;
                    chk(first_fall > B_PAUSE, "R2 pause before first refresh", first_fall, B_PAUSE);
                end
                if (init_done) begin
                    served_total++;
                    chk(gnt == 1'b1, "R9 no refresh without grant", gnt, 1);
                end else begin
                    init_falls++;
                end
                n_falls++;
                since_fall = 0;
            end
            if (!ras_n && p_ras == 1'b0) since_fall++;
            if (!ras_n && p_ras == 1'b1) since_fall = 0;
            if (!p_cas && cas_n && !ras_n)
                chk(since_fall + 1 >= E_CHR, "R4 cas hold after ras fall", since_fall + 1, E_CHR);
            if (!p_ras && ras_n) chk(ras_lo == E_RAS, "R5 ras low width", ras_lo, E_RAS);
            // u1 row-only variant
            if (!u1_cas_n) chk(1'b0, "R12 cas never low in row-only mode", 0, 1);
            if (p_u1ras && !u1_ras_n) begin
                chk(int'(u1_addr) == (u1_k % B_ROWS), "R12 row counter address", int'(u1_addr), u1_k % B_ROWS);
                u1_k++;
            end
            // update counters
            ras_hi = ras_n ? ras_hi + 1 : 0;
            ras_lo = ras_n ? 0 : ras_lo + 1;
            cas_lo = cas_n ? 0 : cas_lo + 1;
            p_ras = ras_n;
            p_cas = cas_n;
            p_u1ras = u1_ras_n;
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog expired", wd, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic drain();
        gnt = 1'b1;
        @(negedge clk);
        while (req) @(negedge clk);
        gnt = 1'b0;
    endtask

    initial begin
        int seed;
        int k;
        int t0, s0;
        seed = $urandom(32'h1F2E);
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
        chk(!req && !own && !init_done, "R1 flags low in reset", {req, own, init_done}, 0);
        chk(backlog == 0, "R1 backlog zero in reset", int'(backlog), 0);
        rst = 1'b0;

        // init burst with grant withheld
        while (!init_done) begin
            @(negedge clk);
            chk(!req, "R9 no request before init", req, 0);
        end
        chk(init_falls == B_REFS, "R2 refresh count before init_done", init_falls, B_REFS);

        // first interval
        k = 0;
        while (backlog == 0) begin
            @(negedge clk);
            k++;
        end
        chk(k == B_INT, "R7 first interval length", k, B_INT);
        chk(req == 1'b1, "R9 request with backlog", req, 1);
        chk(init_done == 1'b1, "R2 init_done stays high", init_done, 1);

        // saturate
        while (backlog != B_MAXP) @(negedge clk);
        repeat (2 * B_INT) @(negedge clk);
        chk(backlog == B_MAXP, "R8 backlog saturates", int'(backlog), B_MAXP);
        s0 = served_total;
        chk(s0 == 0, "R9 nothing served without grant", s0, 0);
        drain();
        chk(served_total - s0 == B_MAXP, "R10 saturated backlog served", served_total - s0, B_MAXP);
        chk(backlog == 0, "R10 backlog empty after drain", int'(backlog), 0);

        // random grant gaps
        t0 = ticks_total;
        s0 = served_total;
        for (int i = 0; i < 20; i++) begin
            repeat ($urandom_range(2 * B_INT, 1)) @(negedge clk);
            chk(int'(backlog) <= 3, "R7 backlog bounded by elapsed intervals", int'(backlog), 3);
            drain();
        end
        chk(served_total - s0 == ticks_total - t0, "R10 one refresh per interval",
            served_total - s0, ticks_total - t0);
        chk(u1_k > B_REFS, "R12 row-only variant refreshed", u1_k, B_REFS + 1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule